// File: doc/BRIEF.md
# Peripheral Bus Adapter Register Front End

This block is the register front end of a peripheral bus adapter that sits on a 32-bit host register bus. Every host access is decoded into one of three regions. The internal region holds the adapter's own registers: configuration, control, status, transfer address, byte count, diagnostic and a command word that always reads as zero. The external region forwards 16-bit register accesses to a drive port. The map region reads and writes a page map RAM. Each access gets a registered response one cycle after the request. The response carries read data, a nonexistent-memory flag and an error-confirmation flag.

The block guards the registers that a running data transfer depends on. Software writes to the transfer address or byte count while busy are refused. So are a maintenance request while busy and a second transfer start while busy. Each refusal sets a program-error status bit. Status flags are cleared by writing ones. Clearing interrupt-enable drops any pending interrupt. The data path and the drives are outside this block: transfer completion arrives on a single input, and the drive answers each forwarded access combinationally with data and a two-bit result code.

Top module: `adapter_csr`

## Requirements
- R1: A request whose address bits [1:0] are not 00, or with `long_i` low, changes no state and is not forwarded. One cycle later it responds with `err_cnf_o`=1, `nxm_o`=0 and read data 0. Every request gets `rsp_valid_o` exactly one cycle later.
- R2: Writing ones to the status word clears the flags under the clear mask 0x00013800: bit 16 done, bit 13 program error, bit 12 abort seen, bit 11 missing drive. Writing ones to configuration bits [23:22] clears those flags. Bits written as 0 are left as they are.
- R3: After reset, and after a control write with bit 0 (init) set, the registers hold their reset values: configuration reads 0x00C00020, status reads 0, and address, count and diagnostic read 0. An init write then loads interrupt-enable and maintenance from bits 2 and 3 of the same write. Map contents are kept.
- R4: A control write with bit 1 (abort) set and bit 0 clear has effect only while busy (status bit 31). It then pulses `drv_abort_o` for one cycle, in the response cycle, and sets status bit 12. When not busy it does nothing.
- R5: A control write with bit 3 (maintenance) set while busy sets program error, and bit 3 of the control word reads back as 0.
- R6: `xfer_done_i` clears busy and sets status bit 16. If control bit 2 (interrupt-enable) is set, it also raises `irq_o`. A control write with bit 2 at 0 clears a pending `irq_o`.
- R7: A write to the address register (internal word 3, 17 bits) or to the count register (word 4, 16 bits) while busy sets program error and leaves the register unchanged. When not busy, the write stores the value.
- R8: An external write to drive register 0 is a transfer start when bit 0 (go) is 1 and bits [5:1] are at least 24. A start while busy sets program error and is not forwarded to the drive. A start that the drive accepts sets busy and clears the four flags under the status clear mask.
- R9: When the drive answers code 1 (missing drive), status bit 11 is set. When it answers code 2 (missing register), the response has `nxm_o`=1. Internal word offsets of 7 and above also respond with `nxm_o`=1.
- R10: An external read returns the drive's 16-bit data in bits [15:0] and status bits [31:16] in bits [31:16].
- R11: The count register reads back as the count in bits [15:0] with a copy in bits [31:16]. The command word (offset 6) reads 0. Configuration bits [7:0] always read 0x20.
- R12: The map region (address bit 11 set, index from bits [9:2], 256 entries) stores only the bits under mask 0x801FFFFF and reads the stored value back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host access request, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| long_i | input | 1 | Access is a full 32-bit word |
| addr_i | input | 12 | Byte address: [11]=map, [10]=external, [9:2] word index |
| wdata_i | input | 32 | Write data |
| xfer_done_i | input | 1 | Data transfer finished |
| drv_rdata_i | input | 16 | Drive read data |
| drv_status_i | input | 2 | Drive result: 0 ok, 1 missing drive, 2 missing register |
| rsp_valid_o | output | 1 | Response valid, one cycle after request |
| rdata_o | output | 32 | Response read data |
| nxm_o | output | 1 | Nonexistent-memory response |
| err_cnf_o | output | 1 | Malformed access confirmation |
| drv_req_o | output | 1 | Forwarded drive access |
| drv_we_o | output | 1 | Forwarded access is a write |
| drv_sel_o | output | 3 | Drive number (address bits [9:7]) |
| drv_reg_o | output | 5 | Drive register (address bits [6:2]) |
| drv_wdata_o | output | 16 | Drive write data |
| drv_abort_o | output | 1 | Abort pulse to the drive |
| irq_o | output | 1 | Pending interrupt |

## Verification
The bench uses the default parameters: a 12-bit address giving a 256-entry map, 8 drives of 32 registers each, a 17-bit address register, a 16-bit count and a start threshold of 24. With these values, map entry 255 can be reached at the top of the region. The bench stub treats drive 7 as missing and drive registers 24 and above as missing. That makes both drive error codes reachable, along with the start threshold edge between function codes 23 and 24. The bench runs transfer starts, completion and every busy-time refusal while a transfer is in flight. It compares each response and the interrupt line against its own model on every clock.

// File: rtl/adapter_csr_pkg.sv
package adapter_csr_pkg;
  typedef enum logic [1:0] {RGN_INT = 2'd0, RGN_EXT = 2'd1, RGN_MAP = 2'd2} region_e;
  typedef enum logic [1:0] {DRV_OK = 2'd0, DRV_NXD = 2'd1, DRV_NXR = 2'd2} drv_rsp_e;

  localparam int OFS_CFG  = 0;
  localparam int OFS_CTRL = 1;
  localparam int OFS_STAT = 2;
  localparam int OFS_VA   = 3;
  localparam int OFS_BC   = 4;
  localparam int OFS_DIAG = 5;
  localparam int OFS_CMD  = 6;

  localparam int CT_INIT  = 0;
  localparam int CT_ABORT = 1;
  localparam int CT_IE    = 2;
  localparam int CT_MAINT = 3;

  localparam int ST_BUSY = 31;
  localparam int ST_DONE = 16;
  localparam int ST_PGE  = 13;
  localparam int ST_ABT  = 12;
  localparam int ST_NFD  = 11;
endpackage

// File: rtl/adapter_decode.sv
module adapter_decode
  import adapter_csr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DRV_W  = 3,
  parameter int DREG_W = 5,
  localparam int IDX_W = ADDR_W - 4
) (
  input  logic              req_i,
  input  logic              long_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              bad_o,
  output logic              ok_o,
  output region_e           region_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DRV_W-1:0]  drv_sel_o,
  output logic [DREG_W-1:0] drv_reg_o
);
  logic misfit;
  assign misfit   = (addr_i[1:0] != 2'b00) || !long_i;
  assign bad_o    = req_i && misfit;
  assign ok_o     = req_i && !misfit;
  assign idx_o    = addr_i[ADDR_W-3:2];
  assign drv_reg_o = addr_i[2 +: DREG_W];
  assign drv_sel_o = addr_i[2 + DREG_W +: DRV_W];

  always_comb begin
    if (addr_i[ADDR_W-1])      region_o = RGN_MAP;
    else if (addr_i[ADDR_W-2]) region_o = RGN_EXT;
    else                       region_o = RGN_INT;
  end
endmodule

// File: rtl/adapter_map.sv
module adapter_map #(
  parameter int          IDX_W = 8,
  parameter logic [31:0] WMASK = 32'h801F_FFFF,
  localparam int         DEPTH = 2 ** IDX_W
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);
  logic [31:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i & WMASK;
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/adapter_regs.sv
module adapter_regs
  import adapter_csr_pkg::*;
#(
  parameter int         VA_W      = 17,
  parameter int         BC_W      = 16,
  parameter int         DIAG_W    = 16,
  parameter int         IDX_W     = 8,
  parameter logic [4:0] DT_FN_MIN = 5'd24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              int_wr_i,
  input  logic [IDX_W-1:0]  ofs_i,
  input  logic [31:0]       wdata_i,
  input  logic              ext_acc_i,
  input  logic              ext_wr_i,
  input  logic              ext_cs1_i,
  input  logic [1:0]        drv_status_i,
  input  logic              xfer_done_i,
  output logic [1:0]        cfg_flag_o,
  output logic [31:0]       status_o,
  output logic              ie_o,
  output logic              maint_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic              abort_o,
  output logic              block_o,
  output logic [VA_W-1:0]   va_o,
  output logic [BC_W-1:0]   bc_o,
  output logic [DIAG_W-1:0] diag_o
);
  logic busy_q, done_q, pge_q, abt_q, nfd_q, ie_q, maint_q, irq_q, abort_q;
  logic [1:0]        cfg_q;
  logic [VA_W-1:0]   va_q;
  logic [BC_W-1:0]   bc_q;
  logic [DIAG_W-1:0] diag_q;
  logic              dt_start;
  drv_rsp_e          rsp;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign rsp      = drv_rsp_e'(drv_status_i);
  assign dt_start = ext_wr_i && ext_cs1_i && wdata_i[0] && (wdata_i[5:1] >= DT_FN_MIN);
  assign block_o  = dt_start && busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= 2'b11; busy_q <= 1'b0; done_q <= 1'b0; pge_q <= 1'b0; abt_q <= 1'b0;
      nfd_q <= 1'b0; ie_q <= 1'b0; maint_q <= 1'b0; irq_q <= 1'b0; abort_q <= 1'b0;
      va_q <= '0; bc_q <= '0; diag_q <= '0;
    end else begin
      abort_q <= 1'b0;
      if (xfer_done_i) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        if (ie_q) irq_q <= 1'b1;
      end
      if (int_wr_i) begin
        case (ofs_i)
          IDX_W'(OFS_CFG): cfg_q <= cfg_q & ~wdata_i[23:22];
          IDX_W'(OFS_CTRL): begin
            if (wdata_i[CT_INIT]) begin
              cfg_q <= 2'b11; busy_q <= 1'b0; done_q <= 1'b0; pge_q <= 1'b0;
              abt_q <= 1'b0; nfd_q <= 1'b0; irq_q <= 1'b0;
              va_q <= '0; bc_q <= '0; diag_q <= '0;
              ie_q <= wdata_i[CT_IE];
              maint_q <= wdata_i[CT_MAINT];
            end else begin
              if (wdata_i[CT_ABORT] && busy_q) begin
                abort_q <= 1'b1;
                abt_q   <= 1'b1;
              end
              if (wdata_i[CT_MAINT] && busy_q) begin
                pge_q   <= 1'b1;
                maint_q <= 1'b0;
              end else begin
                maint_q <= wdata_i[CT_MAINT];
              end
              ie_q <= wdata_i[CT_IE];
              if (!wdata_i[CT_IE]) irq_q <= 1'b0;
            end
          end
          IDX_W'(OFS_STAT): begin
            done_q <= done_q & ~wdata_i[ST_DONE];
            pge_q  <= pge_q & ~wdata_i[ST_PGE];
            abt_q  <= abt_q & ~wdata_i[ST_ABT];
            nfd_q  <= nfd_q & ~wdata_i[ST_NFD];
          end
          IDX_W'(OFS_VA): if (busy_q) pge_q <= 1'b1; else va_q <= wdata_i[VA_W-1:0];
          IDX_W'(OFS_BC): if (busy_q) pge_q <= 1'b1; else bc_q <= wdata_i[BC_W-1:0];
          IDX_W'(OFS_DIAG): diag_q <= wdata_i[DIAG_W-1:0];
          default: ;
        endcase
      end
      if (block_o) begin
        pge_q <= 1'b1;
      end else if (ext_acc_i) begin
        if (rsp == DRV_NXD) begin
          nfd_q <= 1'b1;
        end else if (rsp == DRV_OK && dt_start) begin
          busy_q <= 1'b1;
          done_q <= 1'b0; pge_q <= 1'b0; abt_q <= 1'b0; nfd_q <= 1'b0;
        end
      end
    end
  end

  assign status_o   = {busy_q, 14'h0, done_q, 2'b00, pge_q, abt_q, nfd_q, 11'h0};
  assign cfg_flag_o = cfg_q;
  assign ie_o       = ie_q;
  assign maint_o    = maint_q;
  assign busy_o     = busy_q;
  assign irq_o      = irq_q;
  assign abort_o    = abort_q;
  assign va_o       = va_q;
  assign bc_o       = bc_q;
  assign diag_o     = diag_q;
endmodule

// File: rtl/adapter_csr.sv
module adapter_csr
  import adapter_csr_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          DRV_W     = 3,
  parameter int          DREG_W    = 5,
  parameter int          VA_W      = 17,
  parameter int          BC_W      = 16,
  parameter int          DIAG_W    = 16,
  parameter logic [7:0]  CFG_CODE  = 8'h20,
  parameter logic [4:0]  DT_FN_MIN = 5'd24,
  parameter logic [31:0] MAP_WMASK = 32'h801F_FFFF,
  localparam int         IDX_W     = ADDR_W - 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              long_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              xfer_done_i,
  input  logic [15:0]       drv_rdata_i,
  input  logic [1:0]        drv_status_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rdata_o,
  output logic              nxm_o,
  output logic              err_cnf_o,
  output logic              drv_req_o,
  output logic              drv_we_o,
  output logic [DRV_W-1:0]  drv_sel_o,
  output logic [DREG_W-1:0] drv_reg_o,
  output logic [15:0]       drv_wdata_o,
  output logic              drv_abort_o,
  output logic              irq_o
);
  logic              bad_w, ok_w, block_w, ie_w, maint_w, busy_w;
  region_e           region_w;
  logic [IDX_W-1:0]  idx_w;
  logic [1:0]        cfg_flag_w;
  logic [31:0]       status_w, map_rdata_w, rd_data;
  logic [VA_W-1:0]   va_w;
  logic [BC_W-1:0]   bc_w;
  logic [DIAG_W-1:0] diag_w;
  logic              rd_nxm, ext_acc_w;
  logic              rsp_valid_q, nxm_q, err_cnf_q;
  logic [31:0]       rdata_q;

  adapter_decode #(.ADDR_W(ADDR_W), .DRV_W(DRV_W), .DREG_W(DREG_W)) u_decode (
    .req_i(req_i), .long_i(long_i), .addr_i(addr_i), .bad_o(bad_w), .ok_o(ok_w),
    .region_o(region_w), .idx_o(idx_w), .drv_sel_o(drv_sel_o), .drv_reg_o(drv_reg_o)
  );

  assign ext_acc_w = ok_w && (region_w == RGN_EXT);

  adapter_regs #(
    .VA_W(VA_W), .BC_W(BC_W), .DIAG_W(DIAG_W), .IDX_W(IDX_W), .DT_FN_MIN(DT_FN_MIN)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .int_wr_i(ok_w && we_i && (region_w == RGN_INT)), .ofs_i(idx_w), .wdata_i(wdata_i),
    .ext_acc_i(ext_acc_w), .ext_wr_i(ext_acc_w && we_i), .ext_cs1_i(drv_reg_o == '0),
    .drv_status_i(drv_status_i), .xfer_done_i(xfer_done_i),
    .cfg_flag_o(cfg_flag_w), .status_o(status_w), .ie_o(ie_w), .maint_o(maint_w),
    .busy_o(busy_w), .irq_o(irq_o), .abort_o(drv_abort_o), .block_o(block_w),
    .va_o(va_w), .bc_o(bc_w), .diag_o(diag_w)
  );

  adapter_map #(.IDX_W(IDX_W), .WMASK(MAP_WMASK)) u_map (
    .clk_i(clk_i), .we_i(ok_w && we_i && (region_w == RGN_MAP)), .idx_i(idx_w),
    .wdata_i(wdata_i), .rdata_o(map_rdata_w)
  );

  assign drv_req_o   = ext_acc_w && !block_w;
  assign drv_we_o    = we_i;
  assign drv_wdata_o = wdata_i[15:0];

  always_comb begin
    rd_data = '0;
    rd_nxm  = 1'b0;
    case (region_w)
      RGN_INT: begin
        case (idx_w)
          IDX_W'(OFS_CFG):  rd_data = {8'h00, cfg_flag_w, 14'h0, CFG_CODE};
          IDX_W'(OFS_CTRL): rd_data = {28'h0, maint_w, ie_w, 2'b00};
          IDX_W'(OFS_STAT): rd_data = status_w;
          IDX_W'(OFS_VA):   rd_data = 32'(va_w);
          IDX_W'(OFS_BC):   rd_data = {16'(bc_w), 16'(bc_w)};
          IDX_W'(OFS_DIAG): rd_data = 32'(diag_w);
          IDX_W'(OFS_CMD):  rd_data = '0;
          default:          rd_nxm = 1'b1;
        endcase
      end
      RGN_EXT: begin
        if (!block_w) begin
          rd_data = {status_w[31:16], drv_rdata_i};
          rd_nxm  = (drv_rsp_e'(drv_status_i) == DRV_NXR);
        end
      end
      RGN_MAP: rd_data = map_rdata_w;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0; rdata_q <= '0; nxm_q <= 1'b0; err_cnf_q <= 1'b0;
    end else begin
      rsp_valid_q <= req_i;
      rdata_q     <= (ok_w && !we_i) ? rd_data : '0;
      nxm_q       <= ok_w && rd_nxm;
      err_cnf_q   <= bad_w;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rdata_o     = rdata_q;
  assign nxm_o       = nxm_q;
  assign err_cnf_o   = err_cnf_q;
endmodule

// File: rtl/adapter_csr_chk.sv
module adapter_csr_chk #(
  parameter int         ADDR_W    = 12,
  parameter int         VA_W      = 17,
  parameter int         DREG_W    = 5,
  parameter logic [4:0] DT_FN_MIN = 5'd24,
  localparam int        IDX_W     = ADDR_W - 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic              long_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rsp_valid_o,
  input logic              nxm_o,
  input logic              err_cnf_o,
  input logic              drv_req_o,
  input logic              drv_we_o,
  input logic [DREG_W-1:0] drv_reg_o,
  input logic [15:0]       drv_wdata_o,
  input logic              drv_abort_o,
  input logic              irq_o,
  input logic              busy_w,
  input logic              ie_w,
  input logic [VA_W-1:0]   va_w
);
  logic bad_acc, va_wr_busy, start_fwd, unused_chk;

  assign unused_chk = ^drv_wdata_o[15:6];
  assign bad_acc    = req_i && ((addr_i[1:0] != 2'b00) || !long_i);
  assign va_wr_busy = req_i && we_i && !bad_acc && (addr_i[ADDR_W-1:ADDR_W-2] == 2'b00)
                      && (addr_i[ADDR_W-3:2] == IDX_W'(3)) && busy_w;
  assign start_fwd  = drv_req_o && drv_we_o && (drv_reg_o == '0) && drv_wdata_o[0]
                      && (drv_wdata_o[5:1] >= DT_FN_MIN);

  assert_misalign_cnf_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_acc |=> err_cnf_o && rsp_valid_o && !nxm_o);

  assert_rsp_timing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);

  assert_abort_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_abort_o |-> $past(busy_w));

  assert_irq_needs_ie_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ie_w);

  assert_va_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    va_wr_busy |=> $stable(va_w));

  assert_no_start_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_fwd |-> !busy_w);
endmodule

bind adapter_csr adapter_csr_chk #(
  .ADDR_W(ADDR_W), .VA_W(VA_W), .DREG_W(DREG_W), .DT_FN_MIN(DT_FN_MIN)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .long_i(long_i),
  .addr_i(addr_i), .rsp_valid_o(rsp_valid_o), .nxm_o(nxm_o), .err_cnf_o(err_cnf_o),
  .drv_req_o(drv_req_o), .drv_we_o(drv_we_o), .drv_reg_o(drv_reg_o),
  .drv_wdata_o(drv_wdata_o), .drv_abort_o(drv_abort_o), .irq_o(irq_o),
  .busy_w(busy_w), .ie_w(ie_w), .va_w(va_w)
);

// File: tb/test_adapter_csr.sv
module test_adapter_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, lng = 1'b0, xdone = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] drv_rdata;
  logic [1:0]  drv_status;
  logic        rsp_valid, nxm, err_cnf, drv_req, drv_we, drv_abort, irq;
  logic [31:0] rdata;
  logic [2:0]  drv_sel;
  logic [4:0]  drv_reg;
  logic [15:0] drv_wdata;

  int n_chk = 0, n_fail = 0, drv_wr_cnt = 0, m_drv_wr = 0;
  bit running = 1'b0;

  always #4 clk = ~clk;

  adapter_csr i_adapter_csr (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .long_i(lng), .addr_i(addr),
    .wdata_i(wdata), .xfer_done_i(xdone), .drv_rdata_i(drv_rdata), .drv_status_i(drv_status),
    .rsp_valid_o(rsp_valid), .rdata_o(rdata), .nxm_o(nxm), .err_cnf_o(err_cnf),
    .drv_req_o(drv_req), .drv_we_o(drv_we), .drv_sel_o(drv_sel), .drv_reg_o(drv_reg),
    .drv_wdata_o(drv_wdata), .drv_abort_o(drv_abort), .irq_o(irq)
  );

  // drive stub: drive 7 missing, registers 24 and up missing
  always_comb begin
    drv_rdata = {drv_sel, drv_reg, 8'h5A};
    if (drv_sel == 3'd7)       drv_status = 2'd1;
    else if (drv_reg >= 5'd24) drv_status = 2'd2;
    else                       drv_status = 2'd0;
  end
  always @(posedge clk) if (drv_req && drv_we) drv_wr_cnt++;

  // reference model
  logic [1:0]  m_cfg = 2'b11;
  bit          m_busy, m_done, m_pge, m_abt, m_nfd, m_ie, m_maint, m_irq;
  logic [16:0] m_va = '0;
  logic [15:0] m_bc = '0, m_diag = '0;
  logic [31:0] m_map [int];

  function automatic logic [31:0] m_stat();
    return {m_busy, 14'h0, m_done, 2'b00, m_pge, m_abt, m_nfd, 11'h0};
  endfunction

  task automatic model_reset();
    m_cfg = 2'b11; m_busy = 0; m_done = 0; m_pge = 0; m_abt = 0; m_nfd = 0;
    m_ie = 0; m_maint = 0; m_irq = 0; m_va = '0; m_bc = '0; m_diag = '0;
  endtask

  task automatic chk(input bit c, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [11:0] a, input bit lg,
                        input logic [31:0] d, input string tag);
    logic [31:0] e_rd, st;
    bit e_nxm, e_cnf, e_abt, bad, start, blocked, ok;
    int ofs, sel, rg;
    bad = (a[1:0] != 2'b00) || !lg;
    ofs = int'(a[9:2]); sel = int'(a[9:7]); rg = int'(a[6:2]);
    start = w && (a[11:10] == 2'b01) && rg == 0 && d[0] && (d[5:1] >= 5'd24);
    blocked = start && m_busy;
    st = m_stat();
    e_rd = '0; e_nxm = 0; e_cnf = bad; e_abt = 0;
    if (!bad) begin
      if (a[11]) begin
        if (!w) e_rd = m_map[ofs];
      end else if (a[10]) begin
        if (!blocked) begin
          if (sel != 7 && rg >= 24) e_nxm = 1;
          if (!w) e_rd = {st[31:16], 3'(sel), 5'(rg), 8'h5A};
        end
      end else begin
        case (ofs)
          0: e_rd = {8'h00, m_cfg, 14'h0, 8'h20};
          1: e_rd = {28'h0, m_maint, m_ie, 2'b00};
          2: e_rd = st;
          3: e_rd = 32'(m_va);
          4: e_rd = {m_bc, m_bc};
          5: e_rd = 32'(m_diag);
          6: e_rd = '0;
          default: e_nxm = 1;
        endcase
        if (w) e_rd = '0;
        e_abt = w && ofs == 1 && !d[0] && d[1] && m_busy;
      end
    end
    @(negedge clk);
    req = 1; we = w; addr = a; lng = lg; wdata = d;
    @(posedge clk);
    if (!bad) begin
      if (a[11]) begin
        if (w) m_map[ofs] = d & 32'h801F_FFFF;
      end else if (a[10]) begin
        if (blocked) m_pge = 1;
        else begin
          if (sel == 7) m_nfd = 1;
          else if (rg < 24 && start) begin
            m_busy = 1; m_done = 0; m_pge = 0; m_abt = 0; m_nfd = 0;
          end
          if (w) m_drv_wr++;
        end
      end else if (w) begin
        case (ofs)
          0: m_cfg = m_cfg & ~d[23:22];
          1: if (d[0]) begin
               model_reset(); m_ie = d[2]; m_maint = d[3];
             end else begin
               if (d[1] && m_busy) m_abt = 1;
               if (d[3] && m_busy) begin m_pge = 1; m_maint = 0; end
               else m_maint = d[3];
               m_ie = d[2];
               if (!d[2]) m_irq = 0;
             end
          2: begin
               if (d[16]) m_done = 0;
               if (d[13]) m_pge = 0;
               if (d[12]) m_abt = 0;
               if (d[11]) m_nfd = 0;
             end
          3: if (m_busy) m_pge = 1; else m_va = d[16:0];
          4: if (m_busy) m_pge = 1; else m_bc = d[15:0];
          5: m_diag = d[15:0];
          default: ;
        endcase
      end
    end
    @(negedge clk);
    req = 0; we = 0; lng = 0;
    ok = (rsp_valid === 1'b1) && (rdata === e_rd) && (nxm === e_nxm) && (err_cnf === e_cnf)
         && (drv_abort === e_abt) && (drv_wr_cnt == m_drv_wr);
    chk(ok, tag, $sformatf("addr=%h nxm=%b/%b cnf=%b/%b abort=%b/%b drvwr=%0d/%0d rdata",
        a, nxm, e_nxm, err_cnf, e_cnf, drv_abort, e_abt, drv_wr_cnt, m_drv_wr), rdata, e_rd);
  endtask

  task automatic done_pulse();
    @(negedge clk); xdone = 1;
    @(posedge clk);
    m_busy = 0; m_done = 1;
    if (m_ie) m_irq = 1;
    @(negedge clk); xdone = 0;
  endtask

  // per-clock comparison of the interrupt line (R6)
  always @(negedge clk) begin
    if (running) chk(irq === m_irq, "R6", "irq_o", 32'(irq), 32'(m_irq));
  end

  localparam logic [11:0] A_CFG = 12'h000, A_CTRL = 12'h004, A_STAT = 12'h008,
                          A_VA = 12'h00C, A_BC = 12'h010, A_DIAG = 12'h014, A_CMD = 12'h018;

  function automatic logic [11:0] ext_a(input int sel, input int rg);
    return 12'h400 | 12'(sel << 7) | 12'(rg << 2);
  endfunction
  function automatic logic [11:0] map_a(input int i);
    return 12'h800 | 12'(i << 2);
  endfunction

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk(rsp_valid === 0 && irq === 0 && drv_abort === 0 && err_cnf === 0, "R3",
        "outputs in reset", {28'h0, rsp_valid, irq, drv_abort, err_cnf}, '0);
    rst_n = 1;
    running = 1;
    // R3 / R11 reset state
    access(0, A_CFG, 1, 0, "R3");
    access(0, A_STAT, 1, 0, "R3");
    access(0, A_CTRL, 1, 0, "R3");
    access(0, A_VA, 1, 0, "R3");
    // R7 idle writes store
    access(1, A_VA, 1, 32'hFFFE_ABCD, "R7");
    access(0, A_VA, 1, 0, "R7");
    access(1, A_BC, 1, 32'h0000_F00D, "R7");
    access(0, A_BC, 1, 0, "R11");
    access(1, A_DIAG, 1, 32'h0000_1357, "R11");
    access(0, A_DIAG, 1, 0, "R11");
    access(1, A_CMD, 1, 32'hFFFF_FFFF, "R11");
    access(0, A_CMD, 1, 0, "R11");
    // R1 malformed accesses ignored
    access(1, A_VA | 12'h1, 1, 32'h0000_1111, "R1");
    access(1, A_VA, 0, 32'h0000_2222, "R1");
    access(1, A_VA | 12'h2, 0, 32'h0000_3333, "R1");
    access(0, A_VA, 1, 0, "R1");
    access(1, map_a(9) | 12'h3, 1, 32'hFFFF_FFFF, "R1");
    access(0, ext_a(1, 1) | 12'h2, 1, 0, "R1");
    // R2 configuration write-one-to-clear
    access(1, A_CFG, 1, 32'h0080_0000, "R2");
    access(0, A_CFG, 1, 0, "R2");
    // R12 map
    access(1, map_a(5), 1, 32'hFFFF_FFFF, "R12");
    access(1, map_a(255), 1, 32'h1234_5678, "R12");
    access(1, map_a(0), 1, 32'h8000_0001, "R12");
    access(0, map_a(5), 1, 0, "R12");
    access(0, map_a(255), 1, 0, "R12");
    access(0, map_a(0), 1, 0, "R12");
    access(0, map_a(9), 1, 0, "R12");
    // R9 bad internal offsets
    access(0, 12'h01C, 1, 0, "R9");
    access(1, 12'h3FC, 1, 32'hFFFF_FFFF, "R9");
    // R10 / R9 external accesses
    access(0, ext_a(2, 3), 1, 0, "R10");
    access(0, ext_a(2, 30), 1, 0, "R9");
    access(1, ext_a(3, 24), 1, 32'h0000_00FF, "R9");
    access(0, ext_a(7, 1), 1, 0, "R9");
    access(0, A_STAT, 1, 0, "R9");
    access(0, ext_a(4, 5), 1, 0, "R10");
    // R4 abort while idle does nothing
    access(1, A_CTRL, 1, 32'h0000_0002, "R4");
    access(0, A_STAT, 1, 0, "R4");
    // non-transfer function codes do not start
    access(1, ext_a(1, 0), 1, 32'h0000_002F, "R8");
    access(1, ext_a(1, 0), 1, 32'h0000_0030, "R8");
    access(0, A_STAT, 1, 0, "R8");
    // R8 start with interrupts enabled
    access(1, A_CTRL, 1, 32'h0000_0004, "R6");
    access(1, ext_a(1, 0), 1, 32'h0000_0031, "R8");
    access(0, A_STAT, 1, 0, "R8");
    // R7 refused writes while busy
    access(1, A_VA, 1, 32'h0000_0042, "R7");
    access(0, A_VA, 1, 0, "R7");
    access(1, A_BC, 1, 32'h0000_0042, "R7");
    access(0, A_BC, 1, 0, "R7");
    access(0, ext_a(1, 2), 1, 0, "R10");
    // R8 second start refused
    access(1, ext_a(2, 0), 1, 32'h0000_003F, "R8");
    access(1, ext_a(2, 4), 1, 32'h0000_0077, "R8");
    // R5 maintenance while busy
    access(1, A_CTRL, 1, 32'h0000_000C, "R5");
    access(0, A_CTRL, 1, 0, "R5");
    access(0, A_STAT, 1, 0, "R5");
    // R4 abort while busy
    access(1, A_CTRL, 1, 32'h0000_0006, "R4");
    access(0, A_STAT, 1, 0, "R4");
    // R2 status write-one-to-clear, partial then full
    access(1, A_STAT, 1, 32'h0000_2000, "R2");
    access(0, A_STAT, 1, 0, "R2");
    access(1, A_STAT, 1, 32'hFFFF_FFFF, "R2");
    access(0, A_STAT, 1, 0, "R2");
    // R6 completion and interrupt
    done_pulse();
    access(0, A_STAT, 1, 0, "R6");
    access(1, A_VA, 1, 32'h0000_0777, "R7");
    access(0, A_VA, 1, 0, "R7");
    access(1, A_CTRL, 1, 32'h0000_0008, "R6");
    access(0, A_CTRL, 1, 0, "R5");
    // start again clears done, then complete with interrupts off
    access(1, ext_a(0, 0), 1, 32'h0000_0039, "R8");
    access(0, A_STAT, 1, 0, "R8");
    done_pulse();
    access(0, A_STAT, 1, 0, "R6");
    // R3 init write
    access(1, A_BC, 1, 32'h0000_0055, "R3");
    access(1, A_CTRL, 1, 32'h0000_0005, "R3");
    access(0, A_CFG, 1, 0, "R3");
    access(0, A_STAT, 1, 0, "R3");
    access(0, A_VA, 1, 0, "R3");
    access(0, A_BC, 1, 0, "R3");
    access(0, A_CTRL, 1, 0, "R3");
    access(0, map_a(255), 1, 0, "R12");
    running = 0;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule